// File: doc/BRIEF.md
# Descriptor-Driven DMA Transfer Engine

This block moves 32-bit words between a streaming device port and a buffer in memory. Software does not program an address and a count. It places a three-word descriptor in memory, puts that descriptor's address on `desc_addr`, picks a direction on `start_dir` and pulses `start`. The engine then reads the descriptor through its own memory request port. From it the engine takes the buffer start address, the buffer length in bytes and a status word.

In receive mode the engine writes every word that arrives on the device input stream into consecutive buffer locations. It then sets the owner bit in the descriptor's status word, writes that word back, and raises a level interrupt that stays up until software clears it. In transmit mode the engine reads the buffer one word at a time and sends each word out on the device output stream. A transmit returns to idle with no write-back and no interrupt.

Every edge uses valid/ready handshakes. The memory port allows one request in flight, and the engine stalls on either side without dropping a word.

Top module: `dma_desc_engine`

## Requirements
- R1: After reset, `busy`, `irq`, `mem_req_valid`, `dev_in_ready` and `dev_out_valid` are all low.
- R2: After an accepted start, the first three memory requests are reads of `desc_addr`, `desc_addr+4` and `desc_addr+8`, in that order. These return the buffer start address, the length in bytes, and the status word, whose bit 0 is the owner bit (1 = engine).
- R3: In receive mode (`start_dir`=1), device input words are written in arrival order to the buffer start address and then to each following address 4 higher. Exactly ceil(length/4) words are taken, and the word just past the buffer is untouched.
- R4: After the last received word is written, the engine writes the status word back to `desc_addr+8` with bit 0 set and all other bits kept as fetched. It then returns to idle with `irq` high.
- R5: `irq` stays high until a cycle with `irq_clear` high, and is low from the following cycle.
- R6: In transmit mode (`start_dir`=0), ceil(length/4) words are read from consecutive buffer addresses and delivered in order on `dev_out_data`. No descriptor write-back takes place and `irq` stays low.
- R7: A memory or device side that holds ready low causes no word to be lost, duplicated or reordered. A pending read request keeps its address, and a pending output word keeps its value, until accepted.
- R8: A `start` pulse is ignored while `busy` is high or while `irq` is high.
- R9: A length of zero moves no data. In receive mode it still performs the owner write-back and raises `irq`. In transmit mode the engine returns to idle with no output word.
- R10: `busy` is high from the cycle after an accepted start until the engine returns to idle. The direction is taken from `start_dir` in the cycle of the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to begin a transfer |
| start_dir | input | 1 | 1 = receive into memory, 0 = transmit from memory |
| desc_addr | input | 32 | Byte address of the descriptor |
| irq_clear | input | 1 | Clears a pending interrupt |
| busy | output | 1 | Transfer in progress |
| irq | output | 1 | Receive completion interrupt, level |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 32 | Request byte address |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read data returned (always accepted) |
| mem_rsp_rdata | input | 32 | Read data |
| dev_in_valid | input | 1 | Device input word present |
| dev_in_ready | output | 1 | Engine accepts the device word |
| dev_in_data | input | 32 | Device input word |
| dev_out_valid | output | 1 | Output word present |
| dev_out_ready | input | 1 | Device accepts the output word |
| dev_out_data | output | 32 | Output word |

## Verification
Receives and transmits run first with every ready held high, then with memory ready, response delay, device valid and device ready all drawn at random. Comparing the two separates a correct data path from one that drops or repeats words under back-pressure. Lengths cover zero, one word, exact multiples of four and odd byte counts, so the rounding and the zero-length write-back path are both tested. A status word with high bits set shows whether the write-back only sets the owner bit. Start pulses during a transfer and during a pending interrupt, aimed at a second descriptor, show whether the engine ignores them: the second descriptor must stay untouched.

// File: rtl/dma_eng_pkg.sv
// Shared types and constants for the descriptor DMA engine.
// Assumes a descriptor of three consecutive words: buffer, length, status.
package dma_eng_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH_REQ,
        ST_FETCH_RSP,
        ST_RX_MOVE,
        ST_OWNER_WR,
        ST_TX_REQ,
        ST_TX_RSP,
        ST_TX_SEND
    } eng_state_t;

    localparam logic [1:0] FLD_BUF   = 2'd0;
    localparam logic [1:0] FLD_LEN   = 2'd1;
    localparam logic [1:0] FLD_STAT  = 2'd2;
    localparam int         OWNER_BIT = 0;
endpackage

// File: rtl/dma_word_ctr.sv
// Address generator and remaining-word counter for one transfer.
// Loads a byte address and a byte length, rounds the length up to whole
// words, and advances by one word per step. Assumes step only when not empty.
module dma_word_ctr #(
    parameter int AW = 32,
    parameter int WB = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_addr,
    input  logic [AW-1:0] load_bytes,
    input  logic          step,
    output logic [AW-1:0] cur_addr,
    output logic          empty
);
    localparam int SH = $clog2(WB);
    localparam int CW = AW - SH + 1;

    logic [CW-1:0] remain_q;
    logic [CW-1:0] load_words;

    // Byte length rounded up to whole words.
    assign load_words = {1'b0, load_bytes[AW-1:SH]} + CW'(|load_bytes[SH-1:0]);
    assign empty      = (remain_q == '0);

    // Address and count registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr <= '0;
            remain_q <= '0;
        end else if (load) begin
            cur_addr <= load_addr;
            remain_q <= load_words;
        end else if (step) begin
            cur_addr <= cur_addr + AW'(WB);
            remain_q <= remain_q - 1'b1;
        end
    end

    AST_STEP_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> !empty);  // R3
    AST_ADDR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> cur_addr == $past(cur_addr) + AW'(WB));  // R3
endmodule

// File: rtl/dma_out_hold.sv
// Single-entry output register for transmit words.
// Holds one word on a valid/ready stream. Assumes load only when empty.
module dma_out_hold #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] load_data,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [DW-1:0] out_data
);
    // Fill on load, drain on handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (load) begin
            out_valid <= 1'b1;
            out_data  <= load_data;
        end else if (out_valid && out_ready) begin
            out_valid <= 1'b0;
        end
    end

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));  // R7
    AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !out_valid);  // R7
endmodule

// File: rtl/dma_desc_engine.sv
// Descriptor-driven DMA engine: fetches a three-word descriptor, then moves
// words device->memory (receive) or memory->device (transmit). A receive ends
// with an owner-bit write-back and a level interrupt.
// Assumes one outstanding memory read; responses are always accepted.
module dma_desc_engine
    import dma_eng_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          start_dir,
    input  logic [AW-1:0] desc_addr,
    input  logic          irq_clear,
    output logic          busy,
    output logic          irq,
    output logic          mem_req_valid,
    input  logic          mem_req_ready,
    output logic          mem_req_write,
    output logic [AW-1:0] mem_req_addr,
    output logic [DW-1:0] mem_req_wdata,
    input  logic          mem_rsp_valid,
    input  logic [DW-1:0] mem_rsp_rdata,
    input  logic          dev_in_valid,
    output logic          dev_in_ready,
    input  logic [DW-1:0] dev_in_data,
    output logic          dev_out_valid,
    input  logic          dev_out_ready,
    output logic [DW-1:0] dev_out_data
);
    localparam int WB = DW / 8;
    localparam int SH = $clog2(WB);

    eng_state_t    state_q;
    logic [AW-1:0] desc_q;
    logic [AW-1:0] buf_q;
    logic [DW-1:0] stat_q;
    logic          dir_rx_q;
    logic [1:0]    fidx_q;
    logic          irq_q;

    logic          ctr_load;
    logic          ctr_step;
    logic [AW-1:0] cur_addr;
    logic          ctr_empty;
    logic          hold_load;
    logic          owner_done;

    assign busy       = (state_q != ST_IDLE);
    assign irq        = irq_q;
    assign ctr_load   = (state_q == ST_FETCH_RSP) && mem_rsp_valid && (fidx_q == FLD_LEN);
    assign owner_done = (state_q == ST_OWNER_WR) && mem_req_ready;

    dma_word_ctr #(.AW(AW), .WB(WB)) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (ctr_load),
        .load_addr  (buf_q),
        .load_bytes (AW'(mem_rsp_rdata)),
        .step       (ctr_step),
        .cur_addr   (cur_addr),
        .empty      (ctr_empty)
    );

    dma_out_hold #(.DW(DW)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (hold_load),
        .load_data (mem_rsp_rdata),
        .out_valid (dev_out_valid),
        .out_ready (dev_out_ready),
        .out_data  (dev_out_data)
    );

    // Request, stream-ready and counter-step decode per state.
    always_comb begin
        mem_req_valid = 1'b0;
        mem_req_write = 1'b0;
        mem_req_addr  = '0;
        mem_req_wdata = '0;
        dev_in_ready  = 1'b0;
        ctr_step      = 1'b0;
        hold_load     = 1'b0;
        case (state_q)
            ST_FETCH_REQ: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = desc_q + (AW'(fidx_q) << SH);
            end
            ST_RX_MOVE: begin
                if (!ctr_empty) begin
                    mem_req_valid = dev_in_valid;
                    mem_req_write = 1'b1;
                    mem_req_addr  = cur_addr;
                    mem_req_wdata = dev_in_data;
                    dev_in_ready  = mem_req_ready;
                    ctr_step      = dev_in_valid && mem_req_ready;
                end
            end
            ST_OWNER_WR: begin
                mem_req_valid = 1'b1;
                mem_req_write = 1'b1;
                mem_req_addr  = desc_q + (AW'(FLD_STAT) << SH);
                mem_req_wdata = stat_q | (DW'(1) << OWNER_BIT);
            end
            ST_TX_REQ: begin
                if (!ctr_empty) begin
                    mem_req_valid = 1'b1;
                    mem_req_addr  = cur_addr;
                end
            end
            ST_TX_RSP: begin
                hold_load = mem_rsp_valid;
                ctr_step  = mem_rsp_valid;
            end
            default: ;
        endcase
    end

    // Sequencer: accept start, fetch descriptor, move data, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            desc_q   <= '0;
            buf_q    <= '0;
            stat_q   <= '0;
            dir_rx_q <= 1'b0;
            fidx_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (start && !irq_q) begin
                    desc_q   <= desc_addr;
                    dir_rx_q <= start_dir;
                    fidx_q   <= FLD_BUF;
                    state_q  <= ST_FETCH_REQ;
                end
                ST_FETCH_REQ: if (mem_req_ready) state_q <= ST_FETCH_RSP;
                ST_FETCH_RSP: if (mem_rsp_valid) begin
                    if (fidx_q == FLD_BUF) buf_q <= AW'(mem_rsp_rdata);
                    if (fidx_q == FLD_STAT) begin
                        stat_q  <= mem_rsp_rdata;
                        state_q <= dir_rx_q ? ST_RX_MOVE : ST_TX_REQ;
                    end else begin
                        fidx_q  <= fidx_q + 2'd1;
                        state_q <= ST_FETCH_REQ;
                    end
                end
                ST_RX_MOVE: if (ctr_empty) state_q <= ST_OWNER_WR;
                ST_OWNER_WR: if (mem_req_ready) state_q <= ST_IDLE;
                ST_TX_REQ: begin
                    if (ctr_empty)          state_q <= ST_IDLE;
                    else if (mem_req_ready) state_q <= ST_TX_RSP;
                end
                ST_TX_RSP: if (mem_rsp_valid) state_q <= ST_TX_SEND;
                ST_TX_SEND: if (!dev_out_valid) state_q <= ST_TX_REQ;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Interrupt: set by a finished owner write-back, cleared by software.
    always_ff @(posedge clk) begin
        if (!rst_n)          irq_q <= 1'b0;
        else if (owner_done) irq_q <= 1'b1;
        else if (irq_clear)  irq_q <= 1'b0;
    end

    AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_q && !irq_clear) |=> irq_q);  // R5
    AST_IRQ_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> !busy);  // R4
    AST_START_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && irq_q && start) |=> !busy);  // R8
    AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready && !mem_req_write)
        |=> (mem_req_valid && $stable(mem_req_addr)));  // R7
    AST_RX_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_in_valid && dev_in_ready) |-> (mem_req_valid && mem_req_write
        && mem_req_wdata == dev_in_data));  // R3
    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rsp_valid |-> !mem_req_valid);  // R7
endmodule

// File: tb/dma_desc_engine_test.sv
module dma_desc_engine_test;
    localparam int CLK_PERIOD = 10;
    localparam int MEM_WORDS  = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        start_dir = 1'b0;
    logic [31:0] desc_addr = '0;
    logic        irq_clear = 1'b0;
    logic        busy, irq;
    logic        mem_req_valid, mem_req_write;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr, mem_req_wdata;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_rdata = '0;
    logic        dev_in_valid = 1'b0;
    logic        dev_in_ready;
    logic [31:0] dev_in_data = '0;
    logic        dev_out_valid;
    logic        dev_out_ready = 1'b0;
    logic [31:0] dev_out_data;

    int          n_checks = 0;
    int          n_err = 0;
    int          cycles = 0;
    bit          stall = 1'b0;

    logic [31:0] mem [MEM_WORDS];
    logic [31:0] rx_src [64];
    int          rx_n = 0;
    int          rx_idx = 0;
    logic [31:0] tx_got [64];
    int          tx_cnt = 0;
    logic [31:0] rd_log [8];
    int          rd_cnt = 0;
    bit          pend = 1'b0;
    logic [31:0] pend_addr = '0;

    logic        s_mhs, s_mw, s_rhs, s_dhs_in, s_dhs_out;
    logic [31:0] s_ma, s_md, s_dout;

    dma_desc_engine uut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_dir(start_dir),
        .desc_addr(desc_addr), .irq_clear(irq_clear), .busy(busy), .irq(irq),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_rdata(mem_rsp_rdata), .dev_in_valid(dev_in_valid),
        .dev_in_ready(dev_in_ready), .dev_in_data(dev_in_data),
        .dev_out_valid(dev_out_valid), .dev_out_ready(dev_out_ready),
        .dev_out_data(dev_out_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Sample handshakes at the active edge for the negedge models.
    always @(posedge clk) begin
        s_mhs     <= mem_req_valid && mem_req_ready;
        s_mw      <= mem_req_write;
        s_ma      <= mem_req_addr;
        s_md      <= mem_req_wdata;
        s_rhs     <= mem_rsp_valid;
        s_dhs_in  <= dev_in_valid && dev_in_ready;
        s_dhs_out <= dev_out_valid && dev_out_ready;
        s_dout    <= dev_out_data;
    end

    function automatic bit coin();
        return stall ? ($urandom % 3 != 0) : 1'b1;
    endfunction

    function automatic int words_of(int bytes);
        return (bytes + 3) / 4;
    endfunction

    // Memory and device models, updated away from the active edge.
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            if (s_mhs) begin
                if (s_mw) mem[s_ma[9:2]] = s_md;
                else begin
                    pend = 1'b1;
                    pend_addr = s_ma;
                    if (rd_cnt < 8) rd_log[rd_cnt] = s_ma;
                    rd_cnt++;
                end
            end
            if (s_rhs) mem_rsp_valid = 1'b0;
            if (pend && !mem_rsp_valid && coin()) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_rdata = mem[pend_addr[9:2]];
                pend = 1'b0;
            end
            mem_req_ready = coin();
            if (s_dhs_in) begin
                rx_idx++;
                dev_in_valid = 1'b0;
            end
            if (!dev_in_valid && rx_idx < rx_n && coin()) dev_in_valid = 1'b1;
            dev_in_data = rx_src[rx_idx % 64];
            if (s_dhs_out) begin
                if (tx_cnt < 64) tx_got[tx_cnt] = s_dout;
                tx_cnt++;
            end
            dev_out_ready = coin();
        end
    end

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(negedge clk) begin
        if (cycles > 150000) begin
            n_err++;
            n_checks++;
            $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cycles);
            finish_run();
        end
    end

    task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic set_desc(int d, logic [31:0] b, int len, logic [31:0] st);
        mem[d/4] = b;
        mem[d/4 + 1] = 32'(len);
        mem[d/4 + 2] = st;
    endtask

    // Pulse start; busy must be high at the next sample (R10).
    task automatic kick(int d, bit dir);
        start_dir = dir;
        desc_addr = 32'(d);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        start_dir = ~dir;
        check(busy === 1'b1, "R10", "busy after start", {31'd0, busy}, 32'd1);
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        @(negedge clk);
        check(busy === 1'b0, "R10", "busy low at end", {31'd0, busy}, 32'd0);
    endtask

    task automatic clear_irq();
        irq_clear = 1'b1;
        @(negedge clk);
        irq_clear = 1'b0;
        check(irq === 1'b0, "R5", "irq after clear", {31'd0, irq}, 32'd0);
    endtask

    task automatic run_rx(int d, int b, int len, logic [31:0] st, bit stray);
        int nw = words_of(len);
        set_desc(d, 32'(b), len, st);
        for (int i = 0; i < nw; i++) rx_src[i] = $urandom;
        mem[b/4 + nw] = 32'hDEAD_BEEF;
        set_desc(32'h380, 32'h300, 8, 32'h0);
        rx_n = nw; rx_idx = 0; rd_cnt = 0;
        kick(d, 1'b1);
        if (stray) begin
            repeat (5) @(negedge clk);
            desc_addr = 32'h380; start = 1'b1; start_dir = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        wait_idle();
        check(rd_log[0] == 32'(d) && rd_log[1] == 32'(d + 4) && rd_log[2] == 32'(d + 8),
              "R2", "descriptor read order", rd_log[2], 32'(d + 8));
        check(rx_idx == nw, "R3", "words consumed", 32'(rx_idx), 32'(nw));
        for (int i = 0; i < nw; i++)
            check(mem[b/4 + i] == rx_src[i], len == 0 ? "R9" : "R3", "stored word", mem[b/4 + i], rx_src[i]);
        check(mem[b/4 + nw] == 32'hDEAD_BEEF, "R3", "word past buffer", mem[b/4 + nw], 32'hDEAD_BEEF);
        check(mem[d/4 + 2] == (st | 32'd1), len == 0 ? "R9" : "R4", "owner write-back", mem[d/4 + 2], st | 32'd1);
        check(irq === 1'b1, len == 0 ? "R9" : "R4", "irq raised", {31'd0, irq}, 32'd1);
        if (stray) check(mem[32'h380/4 + 2] == 32'h0, "R8", "stray descriptor untouched", mem[32'h380/4 + 2], 32'h0);
        repeat (3) @(negedge clk);
        check(irq === 1'b1, "R5", "irq holds", {31'd0, irq}, 32'd1);
        // Start while irq pending is ignored (R8).
        desc_addr = 32'h380; start = 1'b1; start_dir = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy === 1'b0, "R8", "start ignored with irq", {31'd0, busy}, 32'd0);
        clear_irq();
    endtask

    task automatic run_tx(int d, int b, int len, logic [31:0] st);
        int nw = words_of(len);
        set_desc(d, 32'(b), len, st);
        for (int i = 0; i < nw; i++) mem[b/4 + i] = $urandom;
        tx_cnt = 0; rx_n = 0; rx_idx = 0; rd_cnt = 0;
        kick(d, 1'b0);
        wait_idle();
        check(tx_cnt == nw, len == 0 ? "R9" : "R6", "words sent", 32'(tx_cnt), 32'(nw));
        for (int i = 0; i < nw && i < 64; i++)
            check(tx_got[i] == mem[b/4 + i], "R6", "sent word", tx_got[i], mem[b/4 + i]);
        check(mem[d/4 + 2] == st, "R6", "status unchanged", mem[d/4 + 2], st);
        check(irq === 1'b0, "R6", "no irq on transmit", {31'd0, irq}, 32'd0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < MEM_WORDS; i++) mem[i] = 32'h0;
        repeat (3) @(negedge clk);
        check(busy === 1'b0 && irq === 1'b0, "R1", "busy/irq at reset", {30'd0, busy, irq}, 32'd0);
        check(mem_req_valid === 1'b0 && dev_in_ready === 1'b0 && dev_out_valid === 1'b0,
              "R1", "handshakes at reset", {29'd0, mem_req_valid, dev_in_ready, dev_out_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        stall = 1'b0;
        run_rx(32'h000, 32'h100, 16, 32'hA5A5_0000, 1'b0);   // R3 full speed
        run_tx(32'h010, 32'h200, 20, 32'h0000_0040);         // R6 full speed
        stall = 1'b1;
        run_rx(32'h020, 32'h140, 13, 32'h0F0F_0002, 1'b1);   // R7 odd length, stray start
        run_tx(32'h030, 32'h240, 1, 32'h0);                  // R6 single word
        run_rx(32'h040, 32'h180, 0, 32'h1234_5670, 1'b0);    // R9 empty receive
        run_tx(32'h050, 32'h280, 0, 32'h0);                  // R9 empty transmit
        for (int k = 0; k < 6; k++) begin
            int len = $urandom % 121;
            if ($urandom % 2) run_rx(32'h060, 32'h100, len, $urandom & 32'hFFFF_FFFE, 1'b0);
            else              run_tx(32'h070, 32'h200, len, $urandom);
        end
        finish_run();
    end
endmodule